// File: doc/BRIEF.md
# Byte-Lane Load/Store Steering Unit

This block sits between a processor core and a data memory that is one full word wide, with one write enable per byte. The core presents a memory opcode, a byte address and a source register value. For stores, the block places the low byte, the low halfword or the whole source value on the memory lanes that the address selects, and enables only those lanes. For loads, it requests the word, then picks the addressed byte or halfword out of the returned word and widens it to a full word, with a sign or zero fill chosen by the opcode.

Byte order is big-endian: byte offset 0 is the most significant lane. Accesses must be naturally aligned. A misaligned request raises an error flag in the same cycle and reaches the memory with no read and no byte enables. The memory is assumed to read synchronously, so the block registers the size, offset and fill of each load and produces the widened result one cycle after the request. A new request may be presented in that same cycle.

Top module: `lsu_lane_unit`

## Requirements
- R1: Opcodes are 6-bit values: 32 signed byte load, 33 signed halfword load, 35 word load, 36 unsigned byte load, 37 unsigned halfword load, 40 byte store, 41 halfword store, 43 word store. Any other opcode, or a cycle with `req_valid` low, gives no read, no write, all byte enables 0, no alignment error and no load result in the next cycle.
- R2: A word store at an address whose two low bits are 00 asserts `mem_we`, sets all four enables (`mem_be` = 1111), drives the whole source value on `mem_wdata`, and presents the word address (`req_addr` shifted right by 2) on `mem_addr`.
- R3: A byte store at byte offset o (the two low address bits) enables only `mem_be` bit 3-o. Enable bit b covers data bits 8b+7..8b, so offset 0 writes bits 31:24 and offset 3 writes bits 7:0. The lane carries the source bits 7:0.
- R4: A halfword store at offset 0 sets `mem_be` = 1100, with source bits 15:0 on data bits 31:16. At offset 2 it sets `mem_be` = 0011, with source bits 15:0 on data bits 15:0.
- R5: A word load returns the memory word unchanged on `load_data`.
- R6: Signed byte and signed halfword loads return the big-endian selected byte or halfword, sign-extended to 32 bits.
- R7: Unsigned byte and unsigned halfword loads return the selected byte or halfword, zero-extended to 32 bits.
- R8: A halfword access with address bit 0 set, or a word access with either low address bit set, raises `align_err` in the request cycle. It then asserts neither `mem_re` nor `mem_we`, drives `mem_be` = 0000, and produces no load result.
- R9: `load_valid` is 0 during and after reset. It is 1 for exactly the one cycle that follows each accepted aligned load, and `load_data` is valid in that cycle.
- R10: The result of a load can appear in the same cycle as a new request. A store to the same word in that cycle does not alter the returned value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Memory opcode |
| req_addr | input | 32 | Byte address |
| req_src | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Word from memory, one cycle after `mem_re` |
| align_err | output | 1 | Misaligned request flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The result of a load and a new request can fall in the same cycle. The new request may be a store to the same word or a misaligned access. The bench provokes this by issuing requests back to back, with no idle cycles. While the previous load's result is checked, it also checks the current request's enables, write data and error flag. One directed sequence loads a word and stores to it in the very next cycle. The returned value must be the contents before the store, and a later load must then see the stored value.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   localparam logic [5:0] OP_LDB  = 6'd32;
   localparam logic [5:0] OP_LDH  = 6'd33;
   localparam logic [5:0] OP_LDW  = 6'd35;
   localparam logic [5:0] OP_LDBU = 6'd36;
   localparam logic [5:0] OP_LDHU = 6'd37;
   localparam logic [5:0] OP_STB  = 6'd40;
   localparam logic [5:0] OP_STH  = 6'd41;
   localparam logic [5:0] OP_STW  = 6'd43;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic      is_mem;
      logic      is_store;
      acc_size_e size;
      logic      zext;
   } acc_ctl_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_lane_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  logic [5:0]       op,
   input  logic [OFF_W-1:0] off,
   output acc_ctl_t         ctl,
   output logic             misalign
);

   always_comb begin
      ctl = '{is_mem: 1'b0, is_store: 1'b0, size: SZ_BYTE, zext: 1'b0};
      unique case (op)
         OP_LDB:  ctl = '{is_mem: 1'b1, is_store: 1'b0, size: SZ_BYTE, zext: 1'b0};
         OP_LDH:  ctl = '{is_mem: 1'b1, is_store: 1'b0, size: SZ_HALF, zext: 1'b0};
         OP_LDW:  ctl = '{is_mem: 1'b1, is_store: 1'b0, size: SZ_WORD, zext: 1'b0};
         OP_LDBU: ctl = '{is_mem: 1'b1, is_store: 1'b0, size: SZ_BYTE, zext: 1'b1};
         OP_LDHU: ctl = '{is_mem: 1'b1, is_store: 1'b0, size: SZ_HALF, zext: 1'b1};
         OP_STB:  ctl = '{is_mem: 1'b1, is_store: 1'b1, size: SZ_BYTE, zext: 1'b0};
         OP_STH:  ctl = '{is_mem: 1'b1, is_store: 1'b1, size: SZ_HALF, zext: 1'b0};
         OP_STW:  ctl = '{is_mem: 1'b1, is_store: 1'b1, size: SZ_WORD, zext: 1'b0};
         default: ;
      endcase
   end

   always_comb begin
      unique case (ctl.size)
         SZ_HALF: misalign = ctl.is_mem & off[0];
         SZ_WORD: misalign = ctl.is_mem & (|off);
         default: misalign = 1'b0;
      endcase
   end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NB    = DATA_W / 8,
   localparam int OFF_W = $clog2(NB)
) (
   input  acc_size_e        size,
   input  logic [OFF_W-1:0] off,
   input  logic [DATA_W-1:0] src,
   output logic [NB-1:0]    be,
   output logic [DATA_W-1:0] wdata
);

   // Offset k (big-endian) lives on enable bit NB-1-k.
   for (genvar k = 0; k < NB; k++) begin : g_lane
      localparam int              BIT  = NB - 1 - k;
      localparam logic [OFF_W-1:0] KOFF = OFF_W'(k);
      localparam bit              HIGH = (k % 2) == 0;

      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               wdata[8*BIT +: 8] = src[7:0];
               be[BIT]           = (off == KOFF);
            end
            SZ_HALF: begin
               wdata[8*BIT +: 8] = HIGH ? src[15:8] : src[7:0];
               be[BIT]           = ((off >> 1) == (KOFF >> 1));
            end
            default: begin
               wdata[8*BIT +: 8] = src[8*BIT +: 8];
               be[BIT]           = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NB    = DATA_W / 8,
   localparam int OFF_W = $clog2(NB)
) (
   input  acc_size_e         size,
   input  logic [OFF_W-1:0]  off,
   input  logic              zext,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);

   logic [7:0]  lane [NB];
   logic [7:0]  sel_b;
   logic [15:0] sel_h;
   logic [OFF_W-1:0] hi_idx, lo_idx;

   for (genvar k = 0; k < NB; k++) begin : g_split
      assign lane[k] = rdata[DATA_W-1-8*k -: 8];
   end

   assign hi_idx = {off[OFF_W-1:1], 1'b0};
   assign lo_idx = {off[OFF_W-1:1], 1'b1};
   assign sel_b  = lane[off];
   assign sel_h  = {lane[hi_idx], lane[lo_idx]};

   always_comb begin
      unique case (size)
         SZ_BYTE: data = {{(DATA_W-8){~zext & sel_b[7]}}, sel_b};
         SZ_HALF: data = {{(DATA_W-16){~zext & sel_h[15]}}, sel_h};
         default: data = rdata;
      endcase
   end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int NB    = DATA_W / 8,
   localparam int OFF_W = $clog2(NB),
   localparam int WA_W  = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [5:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_src,
   output logic [WA_W-1:0]   mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [NB-1:0]     mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              align_err,
   output logic              load_valid,
   output logic [DATA_W-1:0] load_data
);

   if ((DATA_W % 8) != 0 || DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("lsu_lane_unit: DATA_W must be a power of two of at least 32");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr_w
      $error("lsu_lane_unit: ADDR_W too small for the lane offset");
   end

   acc_ctl_t         ctl;
   logic             misalign;
   logic [OFF_W-1:0] off;
   logic [NB-1:0]    lane_be;
   logic             go;

   assign off = req_addr[OFF_W-1:0];

   lsu_decode #(.OFF_W(OFF_W)) u_dec (
      .op       (req_op),
      .off      (off),
      .ctl      (ctl),
      .misalign (misalign)
   );

   lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
      .size  (ctl.size),
      .off   (off),
      .src   (req_src),
      .be    (lane_be),
      .wdata (mem_wdata)
   );

   assign go        = req_valid & ctl.is_mem & ~misalign;
   assign align_err = req_valid & misalign;
   assign mem_addr  = req_addr[ADDR_W-1:OFF_W];
   assign mem_we    = go & ctl.is_store;
   assign mem_re    = go & ~ctl.is_store;
   assign mem_be    = mem_we ? lane_be : '0;

   // Load context held for the cycle in which the memory returns data.
   logic             ld_pend;
   acc_size_e        ld_size;
   logic [OFF_W-1:0] ld_off;
   logic             ld_zext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_pend <= 1'b0;
         ld_size <= SZ_WORD;
         ld_off  <= '0;
         ld_zext <= 1'b0;
      end else begin
         ld_pend <= mem_re;
         if (mem_re) begin
            ld_size <= ctl.size;
            ld_off  <= off;
            ld_zext <= ctl.zext;
         end
      end
   end

   lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
      .size  (ld_size),
      .off   (ld_off),
      .zext  (ld_zext),
      .rdata (mem_rdata),
      .data  (load_data)
   );

   assign load_valid = ld_pend;

   // R8: a flagged request reaches memory with nothing enabled
   p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (mem_be == '0) && !mem_re && !mem_we);

   // R9: a result appears exactly one cycle after an accepted read
   p_result_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> load_valid);
   p_result_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(mem_re));

   // R1: read and write never share a cycle; enables only with a write
   p_no_rw_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));
   p_be_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_be != '0) |-> mem_we);

   // R2, R3, R4: a write enables one lane, a lane pair, or all lanes
   p_store_lane_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                  $countones(mem_be) == NB));

endmodule

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_op = '0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_src = '0;
   logic [29:0] mem_addr;
   logic        mem_re, mem_we;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        align_err, load_valid;
   logic [31:0] load_data;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   lsu_lane_unit u0 (
      .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_src,
      .mem_addr, .mem_re, .mem_we, .mem_be, .mem_wdata, .mem_rdata,
      .align_err, .load_valid, .load_data
   );

   // Simple synchronous-read memory, 16 words
   logic [31:0] mem [16];
   always_ff @(posedge clk) begin
      if (mem_we)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
   end

   typedef struct packed {
      logic [5:0]  op;
      logic [7:0]  a;
      logic [31:0] s;
      logic [3:0]  be;
      logic        err;
      logic [31:0] ld;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t V [NV] = '{
      '{6'd43, 8'd4, 32'h8E280008, 4'b1111, 1'b0, 32'h0},
      '{6'd35, 8'd4, 32'h0,        4'b0000, 1'b0, 32'h8E280008},
      '{6'd32, 8'd4, 32'h0,        4'b0000, 1'b0, 32'hFFFFFF8E},
      '{6'd36, 8'd4, 32'h0,        4'b0000, 1'b0, 32'h0000008E},
      '{6'd32, 8'd7, 32'h0,        4'b0000, 1'b0, 32'h00000008},
      '{6'd33, 8'd4, 32'h0,        4'b0000, 1'b0, 32'hFFFF8E28},
      '{6'd37, 8'd4, 32'h0,        4'b0000, 1'b0, 32'h00008E28},
      '{6'd33, 8'd6, 32'h0,        4'b0000, 1'b0, 32'h00000008},
      '{6'd40, 8'd5, 32'h123456F0, 4'b0100, 1'b0, 32'h0},
      '{6'd35, 8'd4, 32'h0,        4'b0000, 1'b0, 32'h8EF00008},
      '{6'd41, 8'd6, 32'hAAAA9ABC, 4'b0011, 1'b0, 32'h0},
      '{6'd35, 8'd4, 32'h0,        4'b0000, 1'b0, 32'h8EF09ABC},
      '{6'd37, 8'd6, 32'h0,        4'b0000, 1'b0, 32'h00009ABC},
      '{6'd33, 8'd6, 32'h0,        4'b0000, 1'b0, 32'hFFFF9ABC},
      '{6'd40, 8'd7, 32'h0000007F, 4'b0001, 1'b0, 32'h0},
      '{6'd32, 8'd7, 32'h0,        4'b0000, 1'b0, 32'h0000007F},
      '{6'd43, 8'd8, 32'hAE280008, 4'b1111, 1'b0, 32'h0},
      '{6'd35, 8'd8, 32'h0,        4'b0000, 1'b0, 32'hAE280008},
      '{6'd33, 8'd5, 32'h0,        4'b0000, 1'b1, 32'h0},
      '{6'd43, 8'd6, 32'h55555555, 4'b0000, 1'b1, 32'h0},
      '{6'd35, 8'd7, 32'h0,        4'b0000, 1'b1, 32'h0},
      '{6'd41, 8'd3, 32'h66666666, 4'b0000, 1'b1, 32'h0},
      '{6'd0,  8'd4, 32'h77777777, 4'b0000, 1'b0, 32'h0},
      '{6'd35, 8'd4, 32'h0,        4'b0000, 1'b0, 32'h8EF09A7F},
      '{6'd35, 8'd0, 32'h0,        4'b0000, 1'b0, 32'h00000000}
   };

   function automatic bit is_ld(logic [5:0] op);
      return op inside {6'd32, 6'd33, 6'd35, 6'd36, 6'd37};
   endfunction
   function automatic bit is_st(logic [5:0] op);
      return op inside {6'd40, 6'd41, 6'd43};
   endfunction
   function automatic string st_tag(vec_t v);
      if (v.err) return "R8";
      case (v.op)
         6'd43: return "R2";
         6'd40: return "R3";
         6'd41: return "R4";
         default: return "R1";
      endcase
   endfunction
   function automatic string ld_tag(logic [5:0] op);
      case (op)
         6'd35: return "R5";
         6'd32, 6'd33: return "R6";
         default: return "R7";
      endcase
   endfunction
   function automatic logic [31:0] be_mask(logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
      return m;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic drive(vec_t v);
      req_valid = 1'b1;
      req_op    = v.op;
      req_addr  = {24'h0, v.a};
      req_src   = v.s;
   endtask

   task automatic check_req(vec_t v);
      string t;
      t = st_tag(v);
      chk(t, "mem_be", {28'h0, mem_be}, {28'h0, v.be});
      chk(t, "align_err", {31'h0, align_err}, {31'h0, v.err});
      chk(t, "mem_we", {31'h0, mem_we}, {31'h0, is_st(v.op) && !v.err});
      chk(t, "mem_re", {31'h0, mem_re}, {31'h0, is_ld(v.op) && !v.err});
      if (is_st(v.op) && !v.err) begin
         chk(t, "mem_addr", {2'b0, mem_addr}, {24'h0, v.a} >> 2);
         chk(t, "mem_wdata", mem_wdata & be_mask(v.be),
             (v.op == 6'd43 ? v.s :
              v.op == 6'd41 ? {2{v.s[15:0]}} : {4{v.s[7:0]}}) & be_mask(v.be));
      end
   endtask

   task automatic check_resp(vec_t v);
      bit exp_lv;
      exp_lv = is_ld(v.op) && !v.err;
      chk(v.err ? "R8" : (is_ld(v.op) ? "R9" : "R1"), "load_valid",
          {31'h0, load_valid}, {31'h0, exp_lv});
      if (exp_lv) chk(ld_tag(v.op), "load_data", load_data, v.ld);
   endtask

   initial begin
      for (int w = 0; w < 16; w++) mem[w] = 32'h0;
      // Reset: a load request presented during reset yields no result (R9)
      repeat (2) @(negedge clk);
      drive('{6'd35, 8'd4, 32'h0, 4'b0, 1'b0, 32'h0});
      @(negedge clk); #1;
      chk("R9", "load_valid in reset", {31'h0, load_valid}, 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R9", "load_valid after reset", {31'h0, load_valid}, 32'h0);

      // Vector table, back to back: each result is checked beside the next request
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(V[i]);
         #1;
         check_req(V[i]);
         if (i > 0) check_resp(V[i-1]);
      end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check_resp(V[NV-1]);

      // R10: load, then store to the same word in the next cycle
      @(negedge clk);
      drive('{6'd35, 8'd4, 32'h0, 4'b0, 1'b0, 32'h0});
      @(negedge clk);
      drive('{6'd43, 8'd4, 32'h11223344, 4'b1111, 1'b0, 32'h0});
      #1;
      chk("R10", "load_valid with store", {31'h0, load_valid}, 32'h1);
      chk("R10", "old data with store", load_data, 32'h8EF09A7F);
      chk("R10", "store be in same cycle", {28'h0, mem_be}, 32'hF);
      @(negedge clk);
      drive('{6'd32, 8'd6, 32'h0, 4'b0, 1'b0, 32'h0});
      @(negedge clk);
      drive('{6'd43, 8'd5, 32'h0, 4'b0, 1'b1, 32'h0});
      #1;
      chk("R10", "byte load beside misaligned", load_data, 32'h00000033);
      chk("R8", "err beside result", {31'h0, align_err}, 32'h1);
      chk("R8", "no be beside result", {28'h0, mem_be}, 32'h0);
      @(negedge clk);
      drive('{6'd35, 8'd4, 32'h0, 4'b0, 1'b0, 32'h0});
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R10", "store landed", load_data, 32'h11223344);
      chk("R1", "misaligned store wrote nothing", load_data, 32'h11223344);
      @(negedge clk); #1;
      chk("R9", "single-cycle valid", {31'h0, load_valid}, 32'h0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule